// File: doc/BRIEF.md
# Twin Interval Timer Pair

This block holds two down-counting timers that share one tick strobe and one small register port. They differ in how they expire and how they restart. Both are stepped by a one-cycle tick input from an outside prescaler. The interrupt lines they drive go to an interrupt router elsewhere in the chip.

The first timer (timer A) counts down by two per tick, but only while a gate bit in a shared control register is set. On expiry it holds an interrupt level. Software restarts it by touching its status word, and any read or write of that word does this. The second timer (timer B) runs by itself whenever its reload value is nonzero. It steps down by five per tick, and each time it falls below one it reloads and emits a one-cycle interrupt pulse. All counts are signed, so a step past zero is seen as expiry.

Register map, 2-bit word address:

- 0: timer A reload.
- 1: timer A status.
- 2: gate control. Bit 1 enables timer A.
- 3: timer B reload.

Read data is combinational and valid in the same cycle as a read access.

Top module: `dual_interval_timer`

## Requirements
- R1: After synchronous reset, all four registers read as zero and both `irq_a` and `irq_b` are low.
- R2: A write to address 0 loads both the timer A start value and its current count. A read of address 0 returns the start value, not the current count.
- R3: On a tick, timer A's count drops by 2 only when all three hold: the start value is greater than 0, the count is greater than 0, and bit 1 of the gate register (address 2) is set. Otherwise the tick leaves the count unchanged.
- R4: When a tick brings timer A's count to zero or below, `irq_a` rises in the next cycle. It then stays high until an access to address 1.
- R5: Any access to address 1 does two things: it clears `irq_a` and reloads the count from the start value. A write's data is ignored. A read returns the count as it stood before the reload.
- R6: If a tick arrives in the same cycle as an access to address 1, the access takes effect and the tick does not change timer A that cycle.
- R7: While timer B's reload value (address 3) is zero, ticks produce no `irq_b` pulse.
- R8: With a nonzero reload, each tick subtracts 5 from timer B's count, which starts at zero after reset. When the result is below 1, the count is reloaded instead. In that case `irq_b` is high for exactly the next cycle, once per such tick. Writing the reload value does not change the current count.
- R9: The gate register (address 2) and timer B's reload (address 3) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timer step strobe |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register during a read |
| irq_a | output | 1 | Timer A interrupt level |
| irq_b | output | 1 | Timer B interrupt pulse |

## Verification
Two events can fall in the same cycle: a tick and an access to timer A's status word, which both try to update timer A's count. The bench provokes this deliberately, both with the count one step from expiry and with the count already expired. It checks that the status read returns the pre-access count, that `irq_a` is low in the next cycle, and that the count is back at the start value. A long mixed-traffic phase also lets ticks coincide with reload, gate and status accesses; every cycle is judged against a behavioural reference model.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int unsigned ITMR_W = 32;

    // Register word addresses. The order is part of the programming model.
    typedef enum logic [1:0] {
        REG_A_RELOAD = 2'd0,
        REG_A_STATUS = 2'd1,
        REG_GATE     = 2'd2,
        REG_B_RELOAD = 2'd3
    } itmr_reg_e;

    // Decoded per-cycle controls from the register port.
    typedef struct packed {
        logic a_load;     // write to timer A reload
        logic a_touch;    // any access to timer A status
        logic gate_load;  // write to gate register
        logic b_load;     // write to timer B reload
    } itmr_ctl_t;

endpackage

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int unsigned W = ITMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] a_start,
    input  logic [W-1:0] a_count,
    input  logic [W-1:0] b_reload,
    output itmr_ctl_t    ctl,
    output logic [W-1:0] gate_q,
    output logic [W-1:0] bus_rdata
);

    itmr_reg_e reg_sel;
    assign reg_sel = itmr_reg_e'(bus_addr);

    always_comb begin
        ctl           = '0;
        ctl.a_load    = bus_sel && bus_we && (reg_sel == REG_A_RELOAD);
        ctl.a_touch   = bus_sel && (reg_sel == REG_A_STATUS);
        ctl.gate_load = bus_sel && bus_we && (reg_sel == REG_GATE);
        ctl.b_load    = bus_sel && bus_we && (reg_sel == REG_B_RELOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
        end else if (ctl.gate_load) begin
            gate_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (reg_sel)
                REG_A_RELOAD: bus_rdata = a_start;
                REG_A_STATUS: bus_rdata = a_count;
                REG_GATE:     bus_rdata = gate_q;
                REG_B_RELOAD: bus_rdata = b_reload;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/itmr_ack_timer.sv
module itmr_ack_timer
    import itmr_pkg::*;
#(
    parameter int unsigned W    = ITMR_W,
    parameter int unsigned STEP = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         gate_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         touch,
    output logic [W-1:0] start_o,
    output logic [W-1:0] count_o,
    output logic         irq_o
);

    localparam logic signed [W-1:0] STEP_V = W'(STEP);
    localparam logic signed [W-1:0] ZERO_V = '0;

    logic signed [W-1:0] start_q;
    logic signed [W-1:0] count_q;
    logic signed [W-1:0] count_nx;
    logic                irq_q;
    logic                run;

    assign count_nx = count_q - STEP_V;
    assign run      = tick && gate_en && (start_q > ZERO_V) && (count_q > ZERO_V);

    // Priority: reload write, then status access, then tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            count_q <= '0;
            irq_q   <= 1'b0;
        end else if (load) begin
            start_q <= load_val;
            count_q <= load_val;
        end else if (touch) begin
            count_q <= start_q;
            irq_q   <= 1'b0;
        end else if (run) begin
            count_q <= count_nx;
            if (count_nx <= ZERO_V) begin
                irq_q <= 1'b1;
            end
        end
    end

    assign start_o = start_q;
    assign count_o = count_q;
    assign irq_o   = irq_q;

endmodule

// File: rtl/itmr_auto_timer.sv
module itmr_auto_timer
    import itmr_pkg::*;
#(
    parameter int unsigned W    = ITMR_W,
    parameter int unsigned STEP = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] reload_o,
    output logic         pulse_o
);

    localparam logic signed [W-1:0] STEP_V = W'(STEP);
    localparam logic signed [W-1:0] ONE_V  = W'(1);

    logic signed [W-1:0] reload_q;
    logic signed [W-1:0] count_q;
    logic signed [W-1:0] count_nx;
    logic                pulse_q;
    logic                active;

    assign count_nx = count_q - STEP_V;
    assign active   = (reload_q != '0);

    // A tick uses the reload value held before this cycle's write.
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (load) begin
                reload_q <= load_val;
            end
            if (tick && active) begin
                if (count_nx < ONE_V) begin
                    count_q <= reload_q;
                    pulse_q <= 1'b1;
                end else begin
                    count_q <= count_nx;
                end
            end
        end
    end

    assign reload_o = reload_q;
    assign pulse_o  = pulse_q;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import itmr_pkg::*;
#(
    parameter int unsigned W        = ITMR_W,
    parameter int unsigned STEP_A   = 2,
    parameter int unsigned STEP_B   = 5,
    parameter int unsigned GATE_BIT = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         bus_sel,
    input  logic         bus_we,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_a,
    output logic         irq_b
);

    itmr_ctl_t    ctl;
    logic [W-1:0] gate_q;
    logic [W-1:0] a_start;
    logic [W-1:0] a_count;
    logic [W-1:0] b_reload;

    itmr_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .a_start   (a_start),
        .a_count   (a_count),
        .b_reload  (b_reload),
        .ctl       (ctl),
        .gate_q    (gate_q),
        .bus_rdata (bus_rdata)
    );

    itmr_ack_timer #(.W(W), .STEP(STEP_A)) u_tmr_a (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .gate_en  (gate_q[GATE_BIT]),
        .load     (ctl.a_load),
        .load_val (bus_wdata),
        .touch    (ctl.a_touch),
        .start_o  (a_start),
        .count_o  (a_count),
        .irq_o    (irq_a)
    );

    itmr_auto_timer #(.W(W), .STEP(STEP_B)) u_tmr_b (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (ctl.b_load),
        .load_val (bus_wdata),
        .reload_o (b_reload),
        .pulse_o  (irq_b)
    );

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         bus_sel,
    input logic [1:0]   bus_addr,
    input logic         irq_a,
    input logic         irq_b,
    input logic [W-1:0] a_count,
    input logic [W-1:0] b_reload
);

    logic status_acc;
    assign status_acc = bus_sel && (bus_addr == 2'd1);

    // R4: level holds until a status access
    a_r4_irqa_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_a && !status_acc) |=> irq_a);

    // R4: a rising interrupt needs a tick in the cycle before
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_a) |-> $past(tick));

    // R5: a status access clears the level
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        status_acc |=> !irq_a);

    // R3: without tick or register access timer A's count stays put
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!tick && !bus_sel) |=> $stable(a_count));

    // R7: a pulse only follows a tick seen with a nonzero reload
    a_r7_pulse_needs_reload: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> ($past(tick) && ($past(b_reload) != '0)));

endmodule

bind dual_interval_timer itmr_checker #(.W(W)) u_itmr_checker (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .irq_a    (irq_a),
    .irq_b    (irq_b),
    .a_count  (a_count),
    .b_reload (b_reload)
);

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_a;
    logic        irq_b;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_start, m_cnt, m_gate, m_brel, m_bcnt;
    bit m_irqa, m_irqb;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_interval_timer i_dual_interval_timer (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_start;
            2'd1: return m_cnt;
            2'd2: return m_gate;
            default: return m_brel;
        endcase
    endfunction

    // One cycle: drive at negedge, check read data, advance model, check irqs.
    task automatic step(input string tag, input bit t, input bit s, input bit w,
                        input logic [1:0] a, input logic [31:0] d);
        int nx;
        tick = t; bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
        #1;
        if (s && !w) check(tag, bus_rdata, model_read(a));
        m_irqb = 0;
        if (s && w && a == 2'd0) begin
            m_start = d; m_cnt = d;
        end else if (s && a == 2'd1) begin
            m_cnt = m_start; m_irqa = 0;
        end else if (t && m_start > 0 && m_cnt > 0 && m_gate[1]) begin
            m_cnt = m_cnt - 2;
            if (m_cnt <= 0) m_irqa = 1;
        end
        if (t && m_brel != 0) begin
            nx = m_bcnt - 5;
            if (nx < 1) begin m_bcnt = m_brel; m_irqb = 1; end
            else m_bcnt = nx;
        end
        if (s && w && a == 2'd2) m_gate = d;
        if (s && w && a == 2'd3) m_brel = d;
        @(negedge clk);
        check("R4 irq_a", {31'b0, irq_a}, {31'b0, m_irqa});
        check("R8 irq_b", {31'b0, irq_b}, {31'b0, m_irqb});
        tick = 0; bus_sel = 0; bus_we = 0;
    endtask

    task automatic ticks(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 2'd0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_start = 0; m_cnt = 0; m_gate = 0; m_brel = 0; m_bcnt = 0;
        m_irqa = 0; m_irqb = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check("R1 irq_a", {31'b0, irq_a}, 32'd0);
        check("R1 irq_b", {31'b0, irq_b}, 32'd0);
        for (int a = 0; a < 4; a++) step("R1 read", 0, 1, 0, 2'(a), 0);

        // R3: ungated timer A does not move
        step("R2 load", 0, 1, 1, 2'd0, 32'd7);
        ticks("R3 ungated", 3);
        step("R3 count held", 0, 1, 0, 2'd1, 0);

        // R2/R3/R4: gated countdown 7,5,3,1,-1
        step("R9 gate", 0, 1, 1, 2'd2, 32'h2);
        step("R9 gate rd", 0, 1, 0, 2'd2, 0);
        ticks("R3 count", 2);
        step("R2 reload rd", 0, 1, 0, 2'd0, 0);
        ticks("R4 expire", 2);
        ticks("R4 hold", 3);
        // R5: status read returns pre-reload count and clears irq
        step("R5 status rd", 0, 1, 0, 2'd1, 0);
        step("R5 after reload", 0, 1, 0, 2'd1, 0);
        // R5: status write ignores data
        ticks("R5 prep", 4);
        step("R5 status wr", 0, 1, 1, 2'd1, 32'hDEAD);
        step("R5 wr reloaded", 0, 1, 0, 2'd1, 0);

        // R6: tick together with status access, at one step before expiry
        step("R6 load", 0, 1, 1, 2'd0, 32'd2);
        step("R6 tick+acc", 1, 1, 0, 2'd1, 0);
        step("R6 count", 0, 1, 0, 2'd1, 0);
        ticks("R6 expire", 1);
        step("R6 tick+acc exp", 1, 1, 0, 2'd1, 0);
        step("R6 after", 0, 1, 0, 2'd1, 0);

        // R3: zero start never counts
        step("R3 zero start", 0, 1, 1, 2'd0, 32'd0);
        ticks("R3 zero", 3);
        step("R3 zero rd", 0, 1, 0, 2'd1, 0);

        // R7: timer B idle
        ticks("R7 idle", 4);
        // R8: reload 12: immediate pulse, then 7, 2, pulse
        step("R8 load", 0, 1, 1, 2'd3, 32'd12);
        step("R9 breload rd", 0, 1, 0, 2'd3, 0);
        ticks("R8 run", 8);
        step("R8 negative", 0, 1, 1, 2'd3, 32'hFFFF_FFFF);
        ticks("R8 every tick", 3);
        step("R7 stop", 0, 1, 1, 2'd3, 32'd0);
        ticks("R7 stopped", 5);

        // Mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            bit t, s, w;
            logic [1:0] a;
            logic [31:0] d;
            t = ($urandom_range(0, 2) != 0);
            s = ($urandom_range(0, 5) == 0);
            w = $urandom_range(0, 1);
            a = 2'($urandom_range(0, 3));
            case (a)
                2'd2: d = ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h2;
                2'd3: d = ($urandom_range(0, 4) == 0) ? 32'hFFFF_FFFD : 32'($urandom_range(0, 30));
                default: d = ($urandom_range(0, 6) == 0) ? 32'hFFFF_FFF0 : 32'($urandom_range(0, 21));
            endcase
            step("R6 mixed", t, s, w, a, d);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule